// File: doc/BRIEF.md
# Frame Interrupt Pulse Generator

This block raises the processor's maskable interrupt request once per video frame. When the frame sync input rises, the block pulls its active-low interrupt output low and holds it there for a fixed number of system clock cycles. A width counter then releases it. The default of 32 cycles at a 3.5 MHz system clock gives a pulse of about 9 µs.

A faster processor can finish its interrupt handler while the pulse is still low, and would then accept the same request a second time. To prevent this, a turbo-mode flag lets the processor's interrupt acknowledge cycle end the pulse early. An acknowledge cycle is one in which M1 and IORQ are both low. With turbo mode off, the pulse always runs its full length.

The frame sync input is edge-detected against the system clock. A sync pulse of any length therefore produces exactly one request.

Top module: `frame_irq_gen`

## Requirements
- R1: While `rstN` is low, `intN` is high (deasserted), and the width counter is cleared. A reset that arrives in the middle of a pulse ends that pulse at once.
- R2: At the first rising clock edge where `frameSync` is sampled high after being sampled low, `intN` goes low.
- R3: With no early clear, `intN` stays low for exactly `PULSE_CYCLES` clock cycles (default 32) and then returns high.
- R4: Holding `frameSync` high longer than the pulse produces no second pulse. A new pulse needs `frameSync` to be sampled low and then high again.
- R5: With `turboEn` = 1, a clock edge at which `m1N` = 0 and `iorqN` = 0 are both sampled during a pulse ends the pulse at that edge.
- R6: With `turboEn` = 0, an acknowledge cycle (`m1N` = 0 and `iorqN` = 0) does not shorten the pulse.
- R7: With `turboEn` = 1, `m1N` low on its own or `iorqN` low on its own does not shorten the pulse.
- R8: If `frameSync` is already high when reset is released, no pulse starts until `frameSync` has been sampled low and then high.
- R9: A new rising edge of `frameSync` during a pulse restarts the full width from that edge. A start takes priority over an early clear at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame sync pulse, active high |
| m1N | input | 1 | Processor opcode-fetch/acknowledge strobe, active low |
| iorqN | input | 1 | Processor I/O request strobe, active low |
| turboEn | input | 1 | 1 = the acknowledge cycle may end the pulse early |
| intN | output | 1 | Interrupt request to the processor, active low |

## Verification
The bench measures the exact low width of the pulse for acknowledge cycles of each kind and at different positions, in both modes. A design that ignored the mode would cut short every pulse or none. A design that decoded only one of the two strobes would end the pulse on a half acknowledge. A sync pulse held far beyond the pulse width exposes a level-triggered design, which would run two or more back-to-back pulses. Sync held high across reset release, and a fresh sync edge in mid-pulse, catch a design that starts a spurious pulse out of reset or that ignores a restart.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

  // Strobes sent from the control module to the datapath each cycle.
  typedef struct packed {
    logic startPulse;  // sync rising edge seen: begin a full-width pulse
    logic ackClear;    // turbo acknowledge seen: end the pulse now
  } irqStrobes_t;

endpackage

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
  import frame_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSync,
  input  logic        m1N,
  input  logic        iorqN,
  input  logic        turboEn,
  output irqStrobes_t strobes
);

  // Previous sync sample. It resets to 1, so a sync that is already high
  // when reset is released does not count as an edge.
  logic syncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= 1'b1;
    else       syncPrev <= frameSync;
  end

  logic ackCycle;
  assign ackCycle = ~m1N & ~iorqN;

  always_comb begin
    strobes            = '0;
    strobes.startPulse = frameSync & ~syncPrev;
    strobes.ackClear   = turboEn & ackCycle;
  end

endmodule

// File: rtl/frame_irq_datapath.sv
module frame_irq_datapath
  import frame_irq_pkg::*;
#(
  parameter int PULSE_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  irqStrobes_t strobes,
  output logic        pulseActive
);

  localparam int CNT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] widthCnt;
  logic             activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      widthCnt <= '0;
    end else if (strobes.startPulse) begin
      // A start outranks an early clear at the same edge.
      activeQ  <= 1'b1;
      widthCnt <= '0;
    end else if (activeQ) begin
      if (strobes.ackClear || widthCnt == LAST_CNT) begin
        activeQ  <= 1'b0;
        widthCnt <= '0;
      end else begin
        widthCnt <= widthCnt + 1'b1;
      end
    end
  end

  assign pulseActive = activeQ;

endmodule

// File: rtl/frame_irq_gen.sv
module frame_irq_gen
  import frame_irq_pkg::*;
#(
  parameter int PULSE_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameSync,
  input  logic m1N,
  input  logic iorqN,
  input  logic turboEn,
  output logic intN
);

  irqStrobes_t strobes;
  logic        pulseActive;

  frame_irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .m1N       (m1N),
    .iorqN     (iorqN),
    .turboEn   (turboEn),
    .strobes   (strobes)
  );

  frame_irq_datapath #(.PULSE_CYCLES(PULSE_CYCLES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pulseActive (pulseActive)
  );

  assign intN = ~pulseActive;

endmodule

// File: rtl/frame_irq_chk.sv
module frame_irq_chk #(
  parameter int PULSE_CYCLES = 32
) (
  input logic clk,
  input logic rstN,
  input logic frameSync,
  input logic m1N,
  input logic iorqN,
  input logic turboEn,
  input logic intN
);

  // Independent tracking of the low run, restarted on each valid sync edge.
  int  lowRun;
  logic rstPrev;
  logic syncSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun   <= 0;
      rstPrev  <= 1'b0;
      syncSeen <= 1'b1;
    end else begin
      rstPrev  <= 1'b1;
      syncSeen <= frameSync;
      if (frameSync && !syncSeen) lowRun <= 0;
      else if (!intN)             lowRun <= lowRun + 1;
      else                        lowRun <= 0;
    end
  end

  // R1
  reset_release_chk: assert property (@(posedge clk) !rstN |=> intN)
    else $error("intN low after reset");

  // R2
  start_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !syncSeen && rstPrev) |=> !intN)
    else $error("pulse did not start on sync edge");

  // R3
  width_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> lowRun < PULSE_CYCLES)
    else $error("pulse longer than configured width");

  // R6
  normal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!turboEn && !intN && lowRun < PULSE_CYCLES - 1) |=> !intN)
    else $error("pulse ended early in normal mode");

  // R5
  turbo_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (turboEn && !m1N && !iorqN && !(frameSync && !syncSeen)) |=> intN)
    else $error("acknowledge did not end pulse in turbo mode");

endmodule

bind frame_irq_gen frame_irq_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameSync (frameSync),
  .m1N       (m1N),
  .iorqN     (iorqN),
  .turboEn   (turboEn),
  .intN      (intN)
);

// File: tb/frame_irq_gen_test.sv
module frame_irq_gen_test;

  localparam int P = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0;
  logic m1N = 1'b1;
  logic iorqN = 1'b1;
  logic turboEn = 1'b0;
  logic intN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frame_irq_gen #(.PULSE_CYCLES(P)) uut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .m1N(m1N), .iorqN(iorqN), .turboEn(turboEn), .intN(intN)
  );

  // Columns: turbo, ackKind (0 none, 1 both low, 2 M1 only, 3 IORQ only),
  // cycle index of the acknowledge, expected low width.
  localparam int NVEC = 8;
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 0,  P},
    '{0, 1, 5,  P},
    '{1, 1, 5,  5},
    '{1, 2, 5,  P},
    '{1, 3, 7,  P},
    '{1, 0, 0,  P},
    '{1, 1, 1,  1},
    '{0, 1, 31, P}
  };

  function automatic string reqTag(int turbo, int kind);
    if (kind == 0) return "R3";
    if (turbo == 0) return "R6";
    if (kind == 1) return "R5";
    return "R7";
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Raise sync at a falling edge, then count low samples over a window.
  // Acknowledge is driven at falling edge ackAt and released one cycle later.
  task automatic pulse_measure(int kind, int ackAt, int window,
                               bit dropSync, output int lowCount);
    lowCount = 0;
    @(negedge clk);
    frameSync = 1'b1;
    for (int k = 1; k <= window; k++) begin
      @(negedge clk);
      if (!intN) lowCount++;
      if (k == ackAt) begin
        m1N   = !(kind == 1 || kind == 2);
        iorqN = !(kind == 1 || kind == 3);
      end
      if (k == ackAt + 1) begin
        m1N = 1'b1; iorqN = 1'b1;
      end
    end
    m1N = 1'b1; iorqN = 1'b1;
    if (dropSync) frameSync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    // R1: held in reset with sync toggling, output stays high.
    repeat (3) @(negedge clk);
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
    @(negedge clk);
    check(intN == 1'b1, "R1", intN, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(intN == 1'b1, "R1", intN, 1);

    // R2: output low one edge after sync is sampled high.
    @(negedge clk);
    frameSync = 1'b1;
    check(intN == 1'b1, "R2", intN, 1);
    @(negedge clk);
    check(intN == 1'b0, "R2", intN, 0);
    repeat (P + 4) @(negedge clk);
    frameSync = 1'b0;
    repeat (3) @(negedge clk);

    // Table walk: width under each mode and acknowledge pattern.
    for (int v = 0; v < NVEC; v++) begin
      turboEn = VEC[v][0][0];
      pulse_measure(VEC[v][1], VEC[v][2], P + 8, 1'b1, len);
      check(len == VEC[v][3], reqTag(VEC[v][0], VEC[v][1]), len, VEC[v][3]);
    end
    turboEn = 1'b0;

    // R4: sync held for three pulse widths yields one pulse only.
    pulse_measure(0, 0, 3 * P, 1'b1, len);
    check(len == P, "R4", len, P);

    // R8: sync already high at reset release starts nothing.
    rstN = 1'b0;
    frameSync = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    len = 0;
    for (int k = 0; k < P + 8; k++) begin
      @(negedge clk);
      if (!intN) len++;
    end
    check(len == 0, "R8", len, 0);
    frameSync = 1'b0;
    repeat (2) @(negedge clk);
    pulse_measure(0, 0, P + 8, 1'b1, len);
    check(len == P, "R8", len, P);

    // R9: second sync edge at cycle 12 restarts the width: 12 + P low.
    len = 0;
    @(negedge clk);
    frameSync = 1'b1;
    for (int k = 1; k <= 2 * P + 8; k++) begin
      @(negedge clk);
      if (!intN) len++;
      if (k == 10) frameSync = 1'b0;
      if (k == 12) frameSync = 1'b1;
    end
    frameSync = 1'b0;
    check(len == 12 + P, "R9", len, 12 + P);
    repeat (3) @(negedge clk);

    // R9: in turbo mode a restart edge beats an acknowledge at the same edge.
    turboEn = 1'b1;
    @(negedge clk);
    frameSync = 1'b1;
    repeat (4) @(negedge clk);
    frameSync = 1'b0;
    @(negedge clk);
    frameSync = 1'b1;
    m1N = 1'b0; iorqN = 1'b0;
    @(negedge clk);
    m1N = 1'b1; iorqN = 1'b1;
    check(intN == 1'b0, "R9", intN, 0);
    // R5: a later acknowledge still ends it.
    @(negedge clk);
    m1N = 1'b0; iorqN = 1'b0;
    @(negedge clk);
    m1N = 1'b1; iorqN = 1'b1;
    check(intN == 1'b1, "R5", intN, 1);
    frameSync = 1'b0;
    turboEn = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset in mid-pulse ends it at once.
    @(negedge clk);
    frameSync = 1'b1;
    repeat (5) @(negedge clk);
    check(intN == 1'b0, "R1", intN, 0);
    rstN = 1'b0;
    #1;
    check(intN == 1'b1, "R1", intN, 1);
    frameSync = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(intN == 1'b1, "R1", intN, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule